// File: doc/BRIEF.md
# I2C Target Address Matcher

This block sits on the target side of a two-wire serial bus. It watches the clock and data lines and finds each START and STOP condition. After every START it shifts in the first byte, most significant bit first. It then decides whether the byte addresses this device. On a hit it answers with an acknowledge, raises an interrupt flag and stretches the clock until software touches the data register. On a miss it leaves the data line released and stays passive until the next START.

Two configuration words set the decision. The primary word holds a 7-bit address in bits 7:1. The secondary word also carries 7 bits in positions 7:1, and its bit 0 selects how those bits are used. With bit 0 clear, each set bit masks the matching bit of the primary address. With bit 0 set, the seven bits form a second, independent address. Both words reset to zero in the surrounding register file, so the block starts in mask mode with nothing masked.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, `sda_pull_o`, `scl_hold_o`, `match_irq_o` and `rw_o` are all 0.
- R2: With `alt_addr_i[0]` = 0, the received bits 7:1 match when every bit position where `alt_addr_i` holds 1 is ignored and all other positions equal `own_addr_i[7:1]`. An all-zero mask requires an exact match.
- R3: With `alt_addr_i[0]` = 1, the received bits 7:1 match only when they equal `own_addr_i[7:1]` or `alt_addr_i[7:1]`. In this mode no bit is masked.
- R4: On a hit, `sda_pull_o` goes high after the falling SCL edge that ends the 8th bit. It stays high through the 9th clock and falls after the 9th falling SCL edge.
- R5: On a miss, `sda_pull_o` and `match_irq_o` stay 0, and every later clock pulse is ignored until a new START, even one that carries a matching byte.
- R6: `match_irq_o` rises together with the acknowledge. Any cycle with `data_acc_i` high clears it on the next edge, and a clear wins over a set in the same cycle.
- R7: After the acknowledge, `scl_hold_o` stays high until a cycle with `data_acc_i` high, and it is low on the following cycle.
- R8: Received bit 0 (the read/write direction) takes no part in the comparison. On a hit it is latched onto `rw_o`.
- R9: A repeated START at any point restarts reception of the address byte from its first bit.
- R10: A STOP in the middle of the address byte aborts reception. Clock pulses that follow without a START produce no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| scl_hold_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr_i | input | 8 | Primary address in bits 7:1; bit 0 unused |
| alt_addr_i | input | 8 | Bits 7:1 hold the mask or second address; bit 0 selects dual-address mode |
| data_acc_i | input | 1 | One-cycle pulse on a software access to the data register |
| match_irq_o | output | 1 | Address-match interrupt flag |
| rw_o | output | 1 | Direction bit of the last matched byte |

## Verification
The bench drives wired-AND bus lines, so the block's own pulls show up on the lines the master reads. Its reference model runs on every clock.

Three mode cases are aimed at the comparator:
- A byte that differs only in masked positions must be acknowledged. A design that applied the mask inverted, or applied it in dual mode, would refuse this byte.
- In dual mode, a byte that would pass as masked must be refused.
- A byte that differs only in the direction bit must still be acknowledged.

The remaining cases probe the sequencing:
- A matching byte clocked after a refusal, with no new START, must get no answer. A matcher that keeps listening would acknowledge it.
- A repeated START or STOP in the middle of a byte must reset the bit count. A wrong count misplaces the acknowledge slot.
- The clock stretch must outlast a released master clock and must end on the data access. A matcher that forgot to stretch, or never let go, shows up as a wrong SCL level.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_HOLD
  } am_state_e;
endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_sr, sda_sr;
  logic scl_s, sda_s, scl_q, sda_q;

  // bus idles high: reset to 1 so no edge is seen at reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_sr[STAGES-1];
  assign sda_s      = sda_sr[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      byte_o <= '0;
      cnt_q  <= '0;
    end else if (shift_i && !full_o) begin
      byte_o <= {byte_o[BYTE_W-2:0], bit_i};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign full_o = (cnt_q == CNT_W'(BYTE_W));
endmodule

// File: rtl/i2c_am_cmp.sv
module i2c_am_cmp #(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] rx_i,
  input  logic [ADDR_W-1:0] own_i,
  input  logic [ADDR_W-1:0] alt_i,
  input  logic              dual_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] bit_ok;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign bit_ok[i] = alt_i[i] | (rx_i[i] ~^ own_i[i]);
  end

  assign hit_o = dual_i ? ((rx_i == own_i) | (rx_i == alt_i)) : (&bit_ok);
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
  import i2c_am_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_hold_o,
  output logic       sda_pull_o,
  input  logic [7:0] own_addr_i,
  input  logic [7:0] alt_addr_i,
  input  logic       data_acc_i,
  output logic       match_irq_o,
  output logic       rw_o
);
  am_state_e st_q, st_d;
  logic sda_s, scl_rise, scl_fall, start, stop;
  logic sh_clr, sh_en, sh_full, addr_hit, irq_set;
  logic [BYTE_W-1:0] rx_byte;

  i2c_am_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  i2c_am_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .clr_i(sh_clr), .shift_i(sh_en), .bit_i(sda_s),
    .byte_o(rx_byte), .full_o(sh_full)
  );

  i2c_am_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .rx_i(rx_byte[BYTE_W-1:1]), .own_i(own_addr_i[BYTE_W-1:1]),
    .alt_i(alt_addr_i[BYTE_W-1:1]), .dual_i(alt_addr_i[0]), .hit_o(addr_hit)
  );

  assign sh_en = (st_q == ST_ADDR) && scl_rise;

  always_comb begin
    st_d    = st_q;
    sh_clr  = 1'b0;
    irq_set = 1'b0;
    if (start) begin
      st_d   = ST_ADDR;
      sh_clr = 1'b1;
    end else if (stop) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ADDR: if (scl_fall && sh_full) begin
          st_d    = addr_hit ? ST_ACK : ST_IDLE;
          irq_set = addr_hit;
        end
        ST_ACK:  if (scl_fall) st_d = ST_HOLD;
        ST_HOLD: if (data_acc_i) st_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      match_irq_o <= 1'b0;
      rw_o        <= 1'b0;
    end else begin
      st_q <= st_d;
      if (data_acc_i)   match_irq_o <= 1'b0;
      else if (irq_set) match_irq_o <= 1'b1;
      if (irq_set) rw_o <= rx_byte[0];
    end
  end

  assign sda_pull_o = (st_q == ST_ACK);
  assign scl_hold_o = (st_q == ST_HOLD);
endmodule

// File: rtl/i2c_am_chk.sv
module i2c_am_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic data_acc_i,
  input logic scl_hold_i,
  input logic sda_pull_i,
  input logic irq_i,
  input logic hit_i
);
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sda_pull_i && scl_hold_i)); // R4
  AST_ACK_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_i) |-> hit_i); // R2
  AST_IRQ_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_pull_i) |-> (irq_i || $past(data_acc_i))); // R6
  AST_IRQ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc_i |=> !irq_i); // R6
  AST_STRETCH_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_i) |-> scl_hold_i); // R7
  AST_HOLD_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_i && !data_acc_i) |=> scl_hold_i); // R7
  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_hold_i && data_acc_i) |=> !scl_hold_i); // R7
endmodule

bind i2c_addr_match i2c_am_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .data_acc_i(data_acc_i),
  .scl_hold_i(scl_hold_o), .sda_pull_i(sda_pull_o),
  .irq_i(match_irq_o), .hit_i(addr_hit)
);

// File: tb/tb_i2c_addr_match.sv
module tb_i2c_addr_match;
  localparam int H = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, acc = 1'b0;
  logic [7:0] own = 8'h00, alt = 8'h00;
  logic scl_hold, sda_pull, irq, rw;

  wire scl_bus = m_scl & ~scl_hold;
  wire sda_bus = m_sda & ~sda_pull;

  i2c_addr_match dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_hold_o(scl_hold), .sda_pull_o(sda_pull),
    .own_addr_i(own), .alt_addr_i(alt), .data_acc_i(acc),
    .match_irq_o(irq), .rw_o(rw)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural address decision
  function automatic bit ref_hit(input logic [7:0] b);
    int miss = 0;
    if (alt[0]) return (b[7:1] == own[7:1]) || (b[7:1] == alt[7:1]);
    for (int i = 1; i < 8; i++)
      if (!alt[i] && (b[i] != own[i])) miss++;
    return miss == 0;
  endfunction

  // cycle model: 2-cycle line sampling, then edge view
  logic [2:0] hc, hd;
  int   m_ph, m_cnt;
  logic [7:0] m_byte;
  logic m_irq, m_rw;
  logic e_rise, e_fall, e_start, e_stop;

  always_comb begin
    e_rise  = hc[1] & ~hc[2];
    e_fall  = ~hc[1] & hc[2];
    e_start = hc[1] & hc[2] & hd[2] & ~hd[1];
    e_stop  = hc[1] & hc[2] & ~hd[2] & hd[1];
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc <= 3'b111; hd <= 3'b111;
      m_ph <= 0; m_cnt <= 0; m_byte <= 8'h00; m_irq <= 1'b0; m_rw <= 1'b0;
    end else begin
      hc <= {hc[1:0], scl_bus};
      hd <= {hd[1:0], sda_bus};
      if (acc) m_irq <= 1'b0;
      if (e_start) begin
        m_ph <= 1; m_cnt <= 0; m_byte <= 8'h00;
      end else if (e_stop) begin
        m_ph <= 0;
      end else if (m_ph == 1) begin
        if (e_rise && m_cnt < 8) begin
          m_byte <= {m_byte[6:0], hd[1]};
          m_cnt  <= m_cnt + 1;
        end else if (e_fall && m_cnt == 8) begin
          if (ref_hit(m_byte)) begin
            m_ph <= 2; m_rw <= m_byte[0];
            if (!acc) m_irq <= 1'b1;
          end else m_ph <= 0;
        end
      end else if (m_ph == 2) begin
        if (e_fall) m_ph <= 3;
      end else if (m_ph == 3) begin
        if (acc) m_ph <= 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 sda_pull vs model", sda_pull, m_ph == 2);
      chk("R7 scl_hold vs model", scl_hold, m_ph == 3);
      chk("R6 irq vs model", irq, m_irq);
      chk("R8 rw vs model", rw, m_rw);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic scl_up();
    m_scl = 1'b1;
    do @(negedge clk); while (!scl_bus);
  endtask

  task automatic bit_out(input logic b);
    m_sda = b; wait_n(H);
    scl_up(); wait_n(H);
    m_scl = 1'b0; wait_n(H);
  endtask

  task automatic byte_out(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) bit_out(b[i]);
    m_sda = 1'b1; wait_n(H);
    scl_up(); wait_n(H);
    ack = !sda_bus;
    m_scl = 1'b0; wait_n(H);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wait_n(H);
    scl_up(); wait_n(H);
    m_sda = 1'b0; wait_n(H);
    m_scl = 1'b0; wait_n(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wait_n(H);
    scl_up(); wait_n(H);
    m_sda = 1'b1; wait_n(H);
  endtask

  task automatic release_hold();
    m_scl = 1'b1; wait_n(10);
    chk("R7 SCL stretched", scl_bus, 1'b0);
    chk("R6 irq set on match", irq, 1'b1);
    acc = 1'b1; @(negedge clk); acc = 1'b0;
    wait_n(4);
    chk("R7 SCL released after access", scl_bus, 1'b1);
    chk("R6 irq cleared by access", irq, 1'b0);
    m_scl = 1'b0; wait_n(H);
  endtask

  task automatic addr_phase(input logic [7:0] b, input logic exp_ack, input string tag);
    logic ack;
    bus_start();
    byte_out(b, ack);
    chk(tag, ack, exp_ack);
    if (ack) begin
      chk("R8 direction latched", rw, b[0]);
      release_hold();
    end else chk("R5 no irq on miss", irq, 1'b0);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic ack;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1 sda_pull reset", sda_pull, 1'b0);
    chk("R1 scl_hold reset", scl_hold, 1'b0);
    chk("R1 irq reset", irq, 1'b0);
    chk("R1 rw reset", rw, 1'b0);

    // mask mode
    own = 8'h50; alt = 8'h0C;
    addr_phase(8'h5D, 1'b1, "R2 masked bits ignored");
    addr_phase(8'h52, 1'b0, "R2 unmasked bit mismatch");

    // R5: refused byte, then a matching byte without START
    bus_start();
    byte_out(8'h52, ack); chk("R5 miss refused", ack, 1'b0);
    byte_out(8'h50, ack); chk("R5 ignored until START", ack, 1'b0);
    chk("R5 irq stays low", irq, 1'b0);
    bus_stop();

    alt = 8'h00;
    addr_phase(8'h50, 1'b1, "R2 empty mask exact hit");
    addr_phase(8'h58, 1'b0, "R2 empty mask exact miss");
    addr_phase(8'h51, 1'b1, "R8 direction bit excluded");

    // dual-address mode
    alt = 8'h6F;
    addr_phase(8'h6E, 1'b1, "R3 second address hit");
    addr_phase(8'h50, 1'b1, "R3 primary address hit");
    addr_phase(8'h58, 1'b0, "R3 no masking in dual mode");
    addr_phase(8'h6F, 1'b1, "R8 read direction on second address");

    // R9: repeated START mid-byte
    bus_start();
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_start();
    byte_out(8'h6E, ack); chk("R9 restart after repeated START", ack, 1'b1);
    if (ack) release_hold();
    bus_stop();

    // R10: STOP mid-byte, then clocks with no START
    bus_start();
    for (int i = 0; i < 5; i++) bit_out(1'b0);
    bus_stop();
    m_scl = 1'b0; wait_n(H);
    byte_out(8'h50, ack); chk("R10 no ack after STOP", ack, 1'b0);
    chk("R10 no irq after STOP", irq, 1'b0);
    bus_stop();

    wait_n(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule